// File: doc/BRIEF.md
# SD 4-bit Data Block Transmitter

This block writes one data block to an SD card over the four-bit data bus. A 32-bit word stream feeds it: a start word, the payload, the CRC words and an end word, all prepared upstream. The block treats these as plain words and splits each one into nibbles, most significant nibble first. An external clock generator gives two single-cycle strobes, one for each falling and one for each rising edge of the card clock. The block drives one nibble per card clock period, each on a falling edge.

Software supplies the nibble count minus one and starts a block with a `start` pulse. After the last nibble has been held for a full card period, the block releases the bus. It then shifts in a programmed number of status bits from D0, one on each rising edge. It waits for D0 to return high, which means the card is no longer busy. Only then does it offer the captured status word on a valid/ready output stream. If the word stream runs dry while a word is needed, the block reports an underrun. If D0 stays low for too long during the busy wait, it reports a timeout. In both cases it returns to idle.

Top module: `sdtx_block_sender`

## Requirements
- R1: After reset `dat_oe`, `s_ready`, `m_valid`, `busy`, `err_underrun` and `err_timeout` are all 0.
- R2: A `start` pulse seen in idle makes `busy` go high. On each later `tick_fall` the block registers the next nibble on `dat_out` and sets `dat_oe` high. It drives exactly `nib_count_m1`+1 nibbles, and `dat_out` changes only in cycles that follow a `tick_fall`.
- R3: Each input word is sent as eight nibbles, bits 31:28 first and bits 3:0 last. `s_ready` is high only in a `tick_fall` cycle while sending, when every nibble of the previous word has been used. The word on `s_data` in that cycle gives the nibble driven at that edge.
- R4: The final nibble stays on the bus for one full card period. `dat_oe` drops at the next `tick_fall`.
- R5: After the bus is released, the block samples `dat0_in` on `stat_bits_m1`+1 `tick_rise` cycles. Each sample shifts into bit 0 of the status word, so the first bit captured ends up as the most significant captured bit. The status word starts from 0 for each block.
- R6: Once the status bits are captured, the block checks `dat0_in` on every clock. In the cycle after it sees `dat0_in` high, `m_valid` rises with the status word on `m_data`. Both hold unchanged until `m_ready` is high.
- R7: If a word is needed and `s_valid` is low, then in the next cycle `err_underrun` is high for exactly one cycle. In that same cycle `dat_oe` and `busy` are 0, and no word is taken.
- R8: If `dat0_in` stays low for `BUSY_LIMIT` consecutive clocks in the busy wait, `err_timeout` pulses for one cycle. The block goes idle and does not assert `m_valid`.
- R9: A `start` pulse while `busy` is high has no effect on the block in progress.
- R10: Nibbles left over from a partly used final word are discarded. The next block takes a fresh word for its first nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block (honoured only when idle) |
| nib_count_m1 | input | CNT_W | Number of nibbles to send minus one |
| stat_bits_m1 | input | SC_W | Number of status bits to capture minus one |
| tick_fall | input | 1 | Card clock falling-edge strobe |
| tick_rise | input | 1 | Card clock rising-edge strobe |
| s_valid | input | 1 | Input word available |
| s_ready | output | 1 | Input word taken this cycle |
| s_data | input | WORD_W | Input word |
| dat_out | output | 4 | Nibble driven onto the data lines |
| dat_oe | output | 1 | Output enable for the four data lines |
| dat0_in | input | 1 | Sampled level of data line 0 |
| m_valid | output | 1 | Status word available |
| m_ready | input | 1 | Consumer accepts the status word |
| m_data | output | STAT_W | Captured status word |
| busy | output | 1 | A block is in progress |
| err_underrun | output | 1 | One-cycle pulse: input stream ran dry |
| err_timeout | output | 1 | One-cycle pulse: card busy too long |

## Verification
The checker assumes that the two edge strobes are never high in the same cycle. It also assumes that a falling-edge strobe is never followed by another one in the very next cycle, as happens with any card clock slower than the system clock. The bench builds both strobes from a four-cycle phase counter, so they are always a half period apart. It drives `dat0_in` only from the reference model's phase: pseudo-random bits during status capture, a programmed low time during the busy wait, and high otherwise. Each block's source words are queued before its `start` pulse, so the only stream gap is the one the underrun case creates on purpose.

// File: rtl/sdtx_pkg.sv
package sdtx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SEND   = 3'd1,
    ST_HOLD   = 3'd2,
    ST_STATUS = 3'd3,
    ST_BUSYW  = 3'd4,
    ST_REPORT = 3'd5
  } sdtx_state_e;

  localparam int unsigned NIB_W = 4;

endpackage

// File: rtl/sdtx_nibble_shifter.sv
module sdtx_nibble_shifter
  import sdtx_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned NPW   = WORD_W / NIB_W,
  localparam int unsigned PW    = (NPW > 1) ? $clog2(NPW) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              step_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              empty_o,
  output logic [NIB_W-1:0]  nib_o
);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [PW-1:0]     pos_q, pos_d;
  logic [NIB_W-1:0]  nib_q, nib_d;

  assign empty_o = (pos_q == '0);
  assign nib_o   = nib_q;

  always_comb begin
    sh_d  = sh_q;
    pos_d = pos_q;
    nib_d = nib_q;
    if (flush_i) begin
      pos_d = '0;
    end else if (step_i) begin
      if (empty_o) begin
        nib_d = word_i[WORD_W-1 -: NIB_W];
        sh_d  = {word_i[WORD_W-NIB_W-1:0], {NIB_W{1'b0}}};
        pos_d = PW'(NPW - 1);
      end else begin
        nib_d = sh_q[WORD_W-1 -: NIB_W];
        sh_d  = {sh_q[WORD_W-NIB_W-1:0], {NIB_W{1'b0}}};
        pos_d = pos_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      pos_q <= '0;
      nib_q <= '0;
    end else if (flush_i || step_i) begin
      sh_q  <= sh_d;
      pos_q <= pos_d;
      nib_q <= nib_d;
    end
  end

endmodule

// File: rtl/sdtx_status_capture.sv
module sdtx_status_capture #(
  parameter int unsigned STAT_W = 32,
  localparam int unsigned SC_W  = (STAT_W > 1) ? $clog2(STAT_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic [SC_W-1:0]   len_m1_i,
  input  logic              sample_i,
  input  logic              bit_i,
  output logic              last_o,
  output logic [STAT_W-1:0] word_o
);

  logic [STAT_W-1:0] word_q, word_d;
  logic [SC_W-1:0]   cnt_q, cnt_d;

  assign last_o = (cnt_q == '0);
  assign word_o = word_q;

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    if (clear_i) begin
      word_d = '0;
      cnt_d  = len_m1_i;
    end else if (sample_i) begin
      word_d = {word_q[STAT_W-2:0], bit_i};
      if (!last_o) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (clear_i || sample_i) begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/sdtx_busy_timer.sv
module sdtx_busy_timer #(
  parameter int unsigned BUSY_LIMIT = 1000000,
  localparam int unsigned TM_W      = $clog2(BUSY_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);

  logic [TM_W-1:0] cnt_q, cnt_d;

  assign expired_o = (cnt_q == TM_W'(BUSY_LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)                 cnt_d = '0;
    else if (run_i && !expired_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clear_i || run_i)   cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sdtx_block_sender.sv
module sdtx_block_sender
  import sdtx_pkg::*;
#(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned STAT_W     = 32,
  parameter int unsigned BUSY_LIMIT = 1000000,
  localparam int unsigned SC_W      = (STAT_W > 1) ? $clog2(STAT_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  nib_count_m1,
  input  logic [SC_W-1:0]   stat_bits_m1,
  input  logic              tick_fall,
  input  logic              tick_rise,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  output logic [3:0]        dat_out,
  output logic              dat_oe,
  input  logic              dat0_in,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [STAT_W-1:0] m_data,
  output logic              busy,
  output logic              err_underrun,
  output logic              err_timeout
);

  sdtx_state_e      st_q, st_d;
  logic [CNT_W-1:0] nib_q, nib_d;
  logic             oe_q, oe_d;
  logic             eu_q, eu_d;
  logic             et_q, et_d;

  logic start_acc, need_word, underrun, step, last_nib;
  logic sh_empty, stat_sample, stat_last, tm_expired, timeout_hit;

  assign start_acc   = (st_q == ST_IDLE) && start;
  assign need_word   = (st_q == ST_SEND) && tick_fall && sh_empty;
  assign underrun    = need_word && !s_valid;
  assign step        = (st_q == ST_SEND) && tick_fall && !underrun;
  assign last_nib    = (nib_q == '0);
  assign stat_sample = (st_q == ST_STATUS) && tick_rise;
  assign timeout_hit = (st_q == ST_BUSYW) && !dat0_in && tm_expired;

  sdtx_nibble_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (start_acc),
    .step_i  (step),
    .word_i  (s_data),
    .empty_o (sh_empty),
    .nib_o   (dat_out)
  );

  sdtx_status_capture #(.STAT_W(STAT_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (start_acc),
    .len_m1_i (stat_bits_m1),
    .sample_i (stat_sample),
    .bit_i    (dat0_in),
    .last_o   (stat_last),
    .word_o   (m_data)
  );

  sdtx_busy_timer #(.BUSY_LIMIT(BUSY_LIMIT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (st_q != ST_BUSYW),
    .run_i     ((st_q == ST_BUSYW) && !dat0_in),
    .expired_o (tm_expired)
  );

  always_comb begin
    st_d  = st_q;
    nib_d = nib_q;
    oe_d  = oe_q;
    eu_d  = underrun;
    et_d  = timeout_hit;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          nib_d = nib_count_m1;
          st_d  = ST_SEND;
        end
      end
      ST_SEND: begin
        if (underrun) begin
          oe_d = 1'b0;
          st_d = ST_IDLE;
        end else if (step) begin
          oe_d = 1'b1;
          if (last_nib) st_d = ST_HOLD;
          else          nib_d = nib_q - 1'b1;
        end
      end
      ST_HOLD: begin
        if (tick_fall) begin
          oe_d = 1'b0;
          st_d = ST_STATUS;
        end
      end
      ST_STATUS: begin
        if (stat_sample && stat_last) st_d = ST_BUSYW;
      end
      ST_BUSYW: begin
        if (dat0_in)          st_d = ST_REPORT;
        else if (tm_expired)  st_d = ST_IDLE;
      end
      ST_REPORT: begin
        if (m_ready) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      nib_q <= '0;
      oe_q  <= 1'b0;
      eu_q  <= 1'b0;
      et_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      nib_q <= nib_d;
      oe_q  <= oe_d;
      eu_q  <= eu_d;
      et_q  <= et_d;
    end
  end

  assign s_ready      = need_word;
  assign dat_oe       = oe_q;
  assign m_valid      = (st_q == ST_REPORT);
  assign busy         = (st_q != ST_IDLE);
  assign err_underrun = eu_q;
  assign err_timeout  = et_q;

endmodule

// File: rtl/sdtx_block_sender_chk.sv
module sdtx_block_sender_chk #(
  parameter int unsigned STAT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              tick_fall,
  input logic              tick_rise,
  input logic              s_valid,
  input logic              s_ready,
  input logic [3:0]        dat_out,
  input logic              dat_oe,
  input logic              m_valid,
  input logic              m_ready,
  input logic [STAT_W-1:0] m_data,
  input logic              busy,
  input logic              err_underrun,
  input logic              err_timeout
);

  // input assumption: edge strobes never coincide
  p_ticks_apart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_fall && tick_rise));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dat_oe && !s_ready && !m_valid));

  p_nib_only_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_fall |=> $stable(dat_out));

  p_take_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (tick_fall && busy));

  p_release_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_oe && !tick_fall) |=> dat_oe);

  p_report_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  p_underrun_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_underrun |-> (!dat_oe && !busy) ##1 !err_underrun);

  p_timeout_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> (!busy && !m_valid) ##1 !err_timeout);

  p_start_no_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !m_valid && !err_timeout && !err_underrun && !dat_oe && !tick_fall && !tick_rise) |=> busy);

endmodule

bind sdtx_block_sender sdtx_block_sender_chk #(.STAT_W(STAT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .tick_fall    (tick_fall),
  .tick_rise    (tick_rise),
  .s_valid      (s_valid),
  .s_ready      (s_ready),
  .dat_out      (dat_out),
  .dat_oe       (dat_oe),
  .m_valid      (m_valid),
  .m_ready      (m_ready),
  .m_data       (m_data),
  .busy         (busy),
  .err_underrun (err_underrun),
  .err_timeout  (err_timeout)
);

// File: tb/sdtx_block_sender_test.sv
module sdtx_block_sender_test;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 300;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] nib_count_m1;
  logic [4:0]  stat_bits_m1;
  logic        tick_fall, tick_rise;
  logic        s_valid, s_ready;
  logic [31:0] s_data;
  logic [3:0]  dat_out;
  logic        dat_oe, dat0_in;
  logic        m_valid, m_ready;
  logic [31:0] m_data;
  logic        busy, err_underrun, err_timeout;

  sdtx_block_sender #(.BUSY_LIMIT(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .nib_count_m1(nib_count_m1),
    .stat_bits_m1(stat_bits_m1), .tick_fall(tick_fall), .tick_rise(tick_rise),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .dat_out(dat_out),
    .dat_oe(dat_oe), .dat0_in(dat0_in), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .busy(busy), .err_underrun(err_underrun), .err_timeout(err_timeout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  int cyc = 0;
  bit finished = 0;

  // reference model: 0 idle, 1 send, 2 hold, 3 status, 4 busy wait, 5 report
  int          ms = 0;
  int          m_nleft = 0, m_sleft = 0, m_timer = 0;
  logic [3:0]  nq[$];
  logic [31:0] m_status = 0;
  logic [3:0]  exp_dat = 0;
  bit          exp_oe = 0, exp_eu = 0, exp_et = 0;

  // stimulus state
  logic [31:0] src_q[$];
  int          consumed = 0, busy_len = 0, rdelay = 0, wcnt = 0, rcnt = 0, phase = 0;
  int          seen_eu = 0, seen_et = 0, reports = 0;
  bit          took = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    exp_eu = 0;
    exp_et = 0;
    if (!rst_n) begin
      ms = 0; exp_oe = 0; exp_dat = 0; m_status = 0; nq.delete();
    end else begin
      case (ms)
        0: if (start) begin
             m_nleft = nib_count_m1; m_sleft = stat_bits_m1; m_status = 0;
             nq.delete(); ms = 1;
           end
        1: if (tick_fall) begin
             if (nq.size() == 0 && !s_valid) begin
               exp_eu = 1; exp_oe = 0; ms = 0;
             end else begin
               if (nq.size() == 0)
                 for (int k = 7; k >= 0; k--) nq.push_back(s_data[k*4 +: 4]);
               exp_dat = nq.pop_front();
               exp_oe  = 1;
               if (m_nleft == 0) ms = 2; else m_nleft--;
             end
           end
        2: if (tick_fall) begin exp_oe = 0; ms = 3; end
        3: if (tick_rise) begin
             m_status = {m_status[30:0], dat0_in};
             if (m_sleft == 0) begin ms = 4; m_timer = 0; end else m_sleft--;
           end
        4: if (dat0_in) ms = 5;
           else if (m_timer == LIMIT-1) begin exp_et = 1; ms = 0; end
           else m_timer++;
        5: if (m_ready) ms = 0;
        default: ms = 0;
      endcase
    end
  end

  // driver: card clock phase, stream source, card D0 line, consumer
  always @(posedge clk) begin
    #1;
    if (took) begin void'(src_q.pop_front()); consumed++; end
    phase     = (phase + 1) % 4;
    tick_fall = rst_n && (phase == 0);
    tick_rise = rst_n && (phase == 2);
    s_valid   = (src_q.size() > 0);
    s_data    = (src_q.size() > 0) ? src_q[0] : 32'h0;
    lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (ms == 3)      begin dat0_in = lfsr[0]; wcnt = 0; end
    else if (ms == 4) begin dat0_in = (wcnt >= busy_len); wcnt++; end
    else              begin dat0_in = 1'b1; wcnt = 0; end
    if (ms == 5) begin m_ready = (rcnt >= rdelay); rcnt++; end
    else         begin m_ready = 1'b0; rcnt = 0; end
  end

  always @(negedge clk) begin
    took = s_valid && s_ready;
    if (rst_n) begin
      check(dat_oe == exp_oe, "R2 R4 dat_oe", 32'(dat_oe), 32'(exp_oe));
      if (exp_oe) check(dat_out == exp_dat, "R3 dat_out", 32'(dat_out), 32'(exp_dat));
      check(s_ready == (ms == 1 && tick_fall && nq.size() == 0), "R3 s_ready",
            32'(s_ready), 32'(ms == 1 && tick_fall && nq.size() == 0));
      check(m_valid == (ms == 5), "R6 m_valid", 32'(m_valid), 32'(ms == 5));
      if (ms == 5) check(m_data == m_status, "R5 m_data", m_data, m_status);
      check(busy == (ms != 0), "R9 busy", 32'(busy), 32'(ms != 0));
      check(err_underrun == exp_eu, "R7 err_underrun", 32'(err_underrun), 32'(exp_eu));
      check(err_timeout == exp_et, "R8 err_timeout", 32'(err_timeout), 32'(exp_et));
      if (err_underrun) seen_eu++;
      if (err_timeout)  seen_et++;
      if (m_valid && m_ready) reports++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      failures++;
      $display("FAIL R1 watchdog expired actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run_block(input int nm1, input int sm1, input int blen, input int rd, input int extra_start);
    @(posedge clk); #2;
    nib_count_m1 = 16'(nm1); stat_bits_m1 = 5'(sm1); busy_len = blen; rdelay = rd;
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    if (extra_start > 0) begin
      repeat (extra_start) @(posedge clk);
      #2 start = 1'b1;
      @(posedge clk); #2 start = 1'b0;
    end
    do @(negedge clk); while (ms != 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; nib_count_m1 = '0; stat_bits_m1 = '0;
    tick_fall = 0; tick_rise = 0; s_valid = 0; s_data = 0; dat0_in = 1; m_ready = 0;
    repeat (3) @(negedge clk);
    check({dat_oe, s_ready, m_valid, busy, err_underrun, err_timeout} == 6'b0,
          "R1 reset state", 32'({dat_oe, s_ready, m_valid, busy, err_underrun, err_timeout}), 32'h0);
    @(posedge clk); #2 rst_n = 1'b1;

    // full-size block: start, 128 data, 2 CRC, end; 1049 nibbles, 32 status bits
    src_q.push_back(32'hFFFF_FFF0);
    for (int i = 0; i < 128; i++) src_q.push_back(32'h0102_0304 * (i + 1) ^ 32'h5A5A_A5A5);
    src_q.push_back(32'h1234_ABCD);
    src_q.push_back(32'h9876_0F0F);
    src_q.push_back(32'hFFFF_FFFF);
    consumed = 0;
    run_block(1048, 31, 40, 0, 0);
    check(consumed == 132, "R2 R10 words taken full block", 32'(consumed), 32'd132);

    // partial word then fresh word (R10), short status, slow consumer (R6)
    src_q.push_back(32'h1234_5678);
    consumed = 0;
    run_block(4, 4, 0, 5, 0);
    check(consumed == 1, "R10 partial word taken", 32'(consumed), 32'd1);
    src_q.push_back(32'h9ABC_DEF0);
    consumed = 0;
    run_block(7, 0, 7, 2, 0);
    check(consumed == 1, "R10 fresh word taken", 32'(consumed), 32'd1);

    // start pulse during a block (R9)
    src_q.push_back(32'hC3C3_3C3C);
    src_q.push_back(32'h0F1E_2D3C);
    consumed = 0;
    run_block(15, 7, 3, 0, 12);
    check(consumed == 2, "R9 restart ignored", 32'(consumed), 32'd2);

    // underrun: 24 nibbles asked, 2 words supplied (R7)
    src_q.push_back(32'hDEAD_BEEF);
    src_q.push_back(32'h0BAD_F00D);
    seen_eu = 0;
    run_block(23, 3, 0, 0, 0);
    check(seen_eu == 1, "R7 underrun pulses", 32'(seen_eu), 32'd1);

    // busy timeout (R8)
    src_q.push_back(32'h7777_8888);
    seen_et = 0; reports = 0;
    run_block(7, 7, 100000, 0, 0);
    check(seen_et == 1, "R8 timeout pulses", 32'(seen_et), 32'd1);
    check(reports == 0, "R8 no report after timeout", 32'(reports), 32'd0);

    // recovery: normal block after timeout
    src_q.push_back(32'h2468_ACE0);
    reports = 0;
    run_block(7, 15, LIMIT - 5, 1, 0);
    check(reports == 1, "R6 report after long busy", 32'(reports), 32'd1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule